// File: doc/BRIEF.md
# Inset Window Overlay Timing Generator

This block generates the per-pixel timing and fill control for a reduced-size picture inset on a main display raster. It counts pixel-clock periods from each rising edge of the main horizontal sync and lines from each rising edge of the main vertical sync. It then decides, for every pixel, whether the inset covers the main picture. When it does, the block selects one of three sources for that pixel: a sample read from the inset pixel memory, the border colour, or the background colour.

The inset has two fixed sizes, a larger and a smaller one, and the width and the height are selected independently. A border one line high at the top and bottom and `BORDER_PIX` pixels wide at the left and right can be drawn inside the inset. A background mode fills the whole inset with programmed levels. A mute mode fills only the picture area with those levels. The fast-switch output, which selects the inset over the main picture downstream, can be delayed by 0 to 3 pixel clocks relative to the source selector.

Every output is produced one clock after the counter state it describes, with no back-pressure. The pixel memory must accept a read address on each cycle in which `rd_valid` is high, and must answer with a fixed latency.

Top module: `inset_overlay_gen`

## Requirements
- R1: While `rst_n` is low and until the first rising edge of vertical sync, `fast_sw`, `src_sel`, `rd_valid`, `rd_line`, `rd_pix` and the fill levels are all 0.
- R2: The inset covers pixel counts `hpos` through `hpos+W-1`, where the pixel count is 0 in the first clock after a horizontal sync rising edge. W is `PIX_BIG` (229) when `size_h_small` is 0 and `PIX_SMALL` (172) when it is 1.
- R3: The inset covers line counts `vpos` through `vpos+H-1`. H is `LINES_BIG` (69) when `size_v_small` is 0 and `LINES_SMALL` (52) when it is 1.
- R4: `src_sel` encodes 0 = none, 1 = stored pixel, 2 = border, 3 = background. `rd_valid` is 1 exactly when `src_sel` is 1, and `rd_line`/`rd_pix` then give the position relative to the inset's top-left corner. Otherwise both are 0.
- R5: With `border_en` set, `bg_en` clear and `disp_en` set, a pixel inside the inset selects source 2 when it lies in the first or last inset line, or in the first or last `BORDER_PIX` columns.
- R6: For source 2 the fill levels equal `border_y/u/v` when `border_indep` is 1, and Y = all ones with U = V = 0 when it is 0. For sources 0 and 1 the fill levels are 0.
- R7: With `bg_en` set, every inset pixel selects source 3 with fill levels `bg_y/u/v`, and this overrides the border.
- R8: With `mute` set and `bg_en` clear, pixels that would show stored data select source 3 with the background levels instead, while border pixels remain source 2.
- R9: With `disp_en` clear, `src_sel` is 0 and `fast_sw` stays 0 wherever the window would lie.
- R10: `fast_sw` is 1 when `src_sel` is nonzero, delayed by `sw_dly` clocks (0 to 3) relative to `src_sel`.
- R11: A vertical sync rising edge that coincides with a horizontal sync rising edge starts line count 0. Each later horizontal sync rising edge advances the line count by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync_i | input | 1 | Main horizontal sync, rising edge active |
| vsync_i | input | 1 | Main vertical sync, rising edge active |
| disp_en | input | 1 | Inset display enable |
| size_h_small | input | 1 | Width select: 0 large, 1 small |
| size_v_small | input | 1 | Height select: 0 large, 1 small |
| hpos | input | 8 | Inset left edge in pixel clocks |
| vpos | input | 8 | Inset top edge in lines |
| border_en | input | 1 | Draw border |
| border_indep | input | 1 | Use programmed border colour |
| border_y | input | 4 | Border luma level |
| border_u | input | 3 | Border B-Y level |
| border_v | input | 3 | Border R-Y level |
| bg_en | input | 1 | Fill whole inset with background |
| mute | input | 1 | Replace stored picture by background |
| bg_y | input | 4 | Background luma level |
| bg_u | input | 3 | Background B-Y level |
| bg_v | input | 3 | Background R-Y level |
| sw_dly | input | 2 | Fast-switch delay in clocks |
| fast_sw | output | 1 | Inset-over-main select |
| src_sel | output | 2 | Per-pixel source code |
| rd_valid | output | 1 | Memory read request |
| rd_line | output | 7 | Inset line read address |
| rd_pix | output | 8 | Inset pixel read address |
| fill_y | output | 4 | Fill luma level |
| fill_u | output | 3 | Fill B-Y level |
| fill_v | output | 3 | Fill R-Y level |

## Verification
On a border pixel, the border decision competes with the background override, and with the mute substitution, in the same cycle. The bench provokes both cases by running whole frames with the border enabled together with `bg_en`, and then together with `mute`. The scoreboard judges every pixel of those frames against the priority order: background first, then border, then mute, then the stored pixel. In the same way, the disable input is run while the border and background are both on, so that it must suppress every other function on the same pixels.

// File: rtl/inset_pkg.sv
package inset_pkg;
  typedef enum logic [1:0] {
    SRC_NONE    = 2'd0,
    SRC_STORED  = 2'd1,
    SRC_BORDER  = 2'd2,
    SRC_BACKGND = 2'd3
  } src_e;
endpackage

// File: rtl/inset_raster_cnt.sv
module inset_raster_cnt #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hsync_i,
  input  logic             vsync_i,
  output logic [CNT_W-1:0] hcnt,
  output logic [CNT_W-1:0] vcnt
);
  logic hs_q, vs_q;
  logic h_edge, v_edge;

  assign h_edge = hsync_i & ~hs_q;
  assign v_edge = vsync_i & ~vs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_q <= 1'b0;
      vs_q <= 1'b0;
      hcnt <= '1;
      vcnt <= '1;
    end else begin
      hs_q <= hsync_i;
      vs_q <= vsync_i;
      if (h_edge)          hcnt <= '0;
      else if (hcnt != '1) hcnt <= hcnt + CNT_W'(1);
      if (v_edge)                    vcnt <= '0;
      else if (h_edge && vcnt != '1) vcnt <= vcnt + CNT_W'(1);
    end
  end

  // R11: a sync rising edge restarts its count
  p_line_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsync_i) |=> hcnt == '0);
  p_frame_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsync_i) |=> vcnt == '0);
endmodule

// File: rtl/inset_window.sv
module inset_window
  import inset_pkg::*;
#(
  parameter int CNT_W       = 10,
  parameter int POS_W       = 8,
  parameter int PIX_BIG     = 229,
  parameter int PIX_SMALL   = 172,
  parameter int LINES_BIG   = 69,
  parameter int LINES_SMALL = 52,
  parameter int BORDER_PIX  = 4,
  parameter int Y_W         = 4,
  parameter int C_W         = 3,
  localparam int LINE_W     = $clog2(LINES_BIG),
  localparam int PIX_W      = $clog2(PIX_BIG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  hcnt,
  input  logic [CNT_W-1:0]  vcnt,
  input  logic              disp_en,
  input  logic              size_h_small,
  input  logic              size_v_small,
  input  logic [POS_W-1:0]  hpos,
  input  logic [POS_W-1:0]  vpos,
  input  logic              border_en,
  input  logic              border_indep,
  input  logic [Y_W-1:0]    border_y,
  input  logic [C_W-1:0]    border_u,
  input  logic [C_W-1:0]    border_v,
  input  logic              bg_en,
  input  logic              mute,
  input  logic [Y_W-1:0]    bg_y,
  input  logic [C_W-1:0]    bg_u,
  input  logic [C_W-1:0]    bg_v,
  output src_e              src_q,
  output logic              rd_valid,
  output logic [LINE_W-1:0] rd_line,
  output logic [PIX_W-1:0]  rd_pix,
  output logic [Y_W-1:0]    fill_y,
  output logic [C_W-1:0]    fill_u,
  output logic [C_W-1:0]    fill_v
);
  localparam int XW = CNT_W + 1;

  logic [XW-1:0] wid, hgt, x_ext, y_ext, hp_ext, vp_ext, rel_x, rel_y;
  logic          in_h, in_v, on_edge;
  src_e          nxt_src;

  always_comb begin
    wid     = size_h_small ? XW'(PIX_SMALL) : XW'(PIX_BIG);
    hgt     = size_v_small ? XW'(LINES_SMALL) : XW'(LINES_BIG);
    x_ext   = {1'b0, hcnt};
    y_ext   = {1'b0, vcnt};
    hp_ext  = XW'(hpos);
    vp_ext  = XW'(vpos);
    in_h    = (x_ext >= hp_ext) && (x_ext < hp_ext + wid);
    in_v    = (y_ext >= vp_ext) && (y_ext < vp_ext + hgt);
    rel_x   = x_ext - hp_ext;
    rel_y   = y_ext - vp_ext;
    on_edge = (rel_y == '0) || (rel_y == hgt - XW'(1)) ||
              (rel_x < XW'(BORDER_PIX)) || (rel_x >= wid - XW'(BORDER_PIX));
    nxt_src = SRC_NONE;
    if (disp_en && in_h && in_v) begin
      if (bg_en)                       nxt_src = SRC_BACKGND;
      else if (border_en && on_edge)   nxt_src = SRC_BORDER;
      else if (mute)                   nxt_src = SRC_BACKGND;
      else                             nxt_src = SRC_STORED;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q    <= SRC_NONE;
      rd_valid <= 1'b0;
      rd_line  <= '0;
      rd_pix   <= '0;
      fill_y   <= '0;
      fill_u   <= '0;
      fill_v   <= '0;
    end else begin
      src_q    <= nxt_src;
      rd_valid <= (nxt_src == SRC_STORED);
      rd_line  <= (nxt_src == SRC_STORED) ? rel_y[LINE_W-1:0] : '0;
      rd_pix   <= (nxt_src == SRC_STORED) ? rel_x[PIX_W-1:0] : '0;
      case (nxt_src)
        SRC_BORDER: begin
          fill_y <= border_indep ? border_y : '1;
          fill_u <= border_indep ? border_u : '0;
          fill_v <= border_indep ? border_v : '0;
        end
        SRC_BACKGND: begin
          fill_y <= bg_y;
          fill_u <= bg_u;
          fill_v <= bg_v;
        end
        default: begin
          fill_y <= '0;
          fill_u <= '0;
          fill_v <= '0;
        end
      endcase
    end
  end

  // R4: read addresses stay inside the largest inset
  p_addr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (int'(rd_pix) < PIX_BIG) && (int'(rd_line) < LINES_BIG));
  // R6: no fill level without a fill source
  p_fill_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (src_q == SRC_NONE || src_q == SRC_STORED) |->
      (fill_y == '0 && fill_u == '0 && fill_v == '0));
  // R7: background mode never yields stored or border pixels
  p_bg_override_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bg_en |=> (src_q != SRC_STORED && src_q != SRC_BORDER));
  // R9: display off leaves the main picture untouched
  p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_en |=> src_q == SRC_NONE);
endmodule

// File: rtl/inset_sw_delay.sv
module inset_sw_delay #(
  parameter int MAX_DLY = 3,
  localparam int DLY_W  = $clog2(MAX_DLY + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_in,
  input  logic [DLY_W-1:0] dly,
  output logic             sw_out
);
  logic [MAX_DLY-1:0] taps;
  logic [DLY_W-1:0]   idx;

  always_ff @(posedge clk) begin
    if (!rst_n) taps <= '0;
    else        taps <= {taps[MAX_DLY-2:0], sw_in};
  end

  always_comb begin
    idx = dly - DLY_W'(1);
    if (dly == '0)                     sw_out = sw_in;
    else if (int'(dly) > MAX_DLY)      sw_out = taps[MAX_DLY-1];
    else                               sw_out = taps[idx];
  end

  // R10: a steady delay of two reproduces the switch two clocks late
  p_sw_delay_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dly == DLY_W'(2) && $past(dly) == DLY_W'(2) && $past(dly, 2) == DLY_W'(2))
      |-> sw_out == $past(sw_in, 2));
endmodule

// File: rtl/inset_overlay_gen.sv
module inset_overlay_gen
  import inset_pkg::*;
#(
  parameter int CNT_W       = 10,
  parameter int POS_W       = 8,
  parameter int PIX_BIG     = 229,
  parameter int PIX_SMALL   = 172,
  parameter int LINES_BIG   = 69,
  parameter int LINES_SMALL = 52,
  parameter int BORDER_PIX  = 4,
  parameter int Y_W         = 4,
  parameter int C_W         = 3,
  parameter int MAX_DLY     = 3,
  localparam int LINE_W     = $clog2(LINES_BIG),
  localparam int PIX_W      = $clog2(PIX_BIG),
  localparam int DLY_W      = $clog2(MAX_DLY + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync_i,
  input  logic              vsync_i,
  input  logic              disp_en,
  input  logic              size_h_small,
  input  logic              size_v_small,
  input  logic [POS_W-1:0]  hpos,
  input  logic [POS_W-1:0]  vpos,
  input  logic              border_en,
  input  logic              border_indep,
  input  logic [Y_W-1:0]    border_y,
  input  logic [C_W-1:0]    border_u,
  input  logic [C_W-1:0]    border_v,
  input  logic              bg_en,
  input  logic              mute,
  input  logic [Y_W-1:0]    bg_y,
  input  logic [C_W-1:0]    bg_u,
  input  logic [C_W-1:0]    bg_v,
  input  logic [DLY_W-1:0]  sw_dly,
  output logic              fast_sw,
  output logic [1:0]        src_sel,
  output logic              rd_valid,
  output logic [LINE_W-1:0] rd_line,
  output logic [PIX_W-1:0]  rd_pix,
  output logic [Y_W-1:0]    fill_y,
  output logic [C_W-1:0]    fill_u,
  output logic [C_W-1:0]    fill_v
);
  logic [CNT_W-1:0] hcnt, vcnt;
  src_e             src_q;
  logic             sw_now;

  inset_raster_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .hsync_i(hsync_i), .vsync_i(vsync_i),
    .hcnt(hcnt), .vcnt(vcnt)
  );

  inset_window #(
    .CNT_W(CNT_W), .POS_W(POS_W), .PIX_BIG(PIX_BIG), .PIX_SMALL(PIX_SMALL),
    .LINES_BIG(LINES_BIG), .LINES_SMALL(LINES_SMALL), .BORDER_PIX(BORDER_PIX),
    .Y_W(Y_W), .C_W(C_W)
  ) u_win (
    .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .vcnt(vcnt),
    .disp_en(disp_en), .size_h_small(size_h_small), .size_v_small(size_v_small),
    .hpos(hpos), .vpos(vpos), .border_en(border_en), .border_indep(border_indep),
    .border_y(border_y), .border_u(border_u), .border_v(border_v),
    .bg_en(bg_en), .mute(mute), .bg_y(bg_y), .bg_u(bg_u), .bg_v(bg_v),
    .src_q(src_q), .rd_valid(rd_valid), .rd_line(rd_line), .rd_pix(rd_pix),
    .fill_y(fill_y), .fill_u(fill_u), .fill_v(fill_v)
  );

  assign sw_now  = (src_q != SRC_NONE);
  assign src_sel = src_q;

  inset_sw_delay #(.MAX_DLY(MAX_DLY)) u_dly (
    .clk(clk), .rst_n(rst_n), .sw_in(sw_now), .dly(sw_dly), .sw_out(fast_sw)
  );

  // R1: nothing is selected or switched straight after reset
  p_reset_idle_r1: assert property (@(posedge clk)
    $past(!rst_n) |-> (src_sel == 2'd0 && !rd_valid && !fast_sw));
endmodule

// File: tb/inset_overlay_gen_test.sv
module inset_overlay_gen_test;
  localparam int PB = 12, PS = 9, LB = 6, LS = 4, BP = 2;
  localparam int LINE_LEN = 40, FRAME_LINES = 16;
  localparam int LINE_W = $clog2(LB), PIX_W = $clog2(PB);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hsync_i = 0, vsync_i = 0, disp_en = 0, size_h_small = 0, size_v_small = 0;
  logic [7:0] hpos = 8'h20, vpos = 8'h20;
  logic border_en = 0, border_indep = 0, bg_en = 0, mute = 0;
  logic [3:0] border_y = 0, bg_y = 0;
  logic [2:0] border_u = 0, border_v = 0, bg_u = 0, bg_v = 0;
  logic [1:0] sw_dly = 0;
  logic fast_sw, rd_valid;
  logic [1:0] src_sel;
  logic [LINE_W-1:0] rd_line;
  logic [PIX_W-1:0] rd_pix;
  logic [3:0] fill_y;
  logic [2:0] fill_u, fill_v;

  always #2 clk = ~clk;

  inset_overlay_gen #(.PIX_BIG(PB), .PIX_SMALL(PS), .LINES_BIG(LB),
                      .LINES_SMALL(LS), .BORDER_PIX(BP)) uut (
    .clk(clk), .rst_n(rst_n), .hsync_i(hsync_i), .vsync_i(vsync_i),
    .disp_en(disp_en), .size_h_small(size_h_small), .size_v_small(size_v_small),
    .hpos(hpos), .vpos(vpos), .border_en(border_en), .border_indep(border_indep),
    .border_y(border_y), .border_u(border_u), .border_v(border_v),
    .bg_en(bg_en), .mute(mute), .bg_y(bg_y), .bg_u(bg_u), .bg_v(bg_v),
    .sw_dly(sw_dly), .fast_sw(fast_sw), .src_sel(src_sel), .rd_valid(rd_valid),
    .rd_line(rd_line), .rd_pix(rd_pix), .fill_y(fill_y), .fill_u(fill_u), .fill_v(fill_v)
  );

  typedef struct {
    int due; int src; int rv; int line; int pix; int fy; int fu; int fv; string tag;
  } exp_t;
  typedef struct { int due; int sw; string tag; } sw_t;

  exp_t dq[$];
  sw_t  sq[$];
  int cyc = 0, checks = 0, fails = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Expected behaviour derived from the requirements
  function automatic exp_t model(input int x, input int y, input string tag);
    exp_t e;
    int w, h, rx, ry;
    bit edge_px;
    e = '{due: 0, src: 0, rv: 0, line: 0, pix: 0, fy: 0, fu: 0, fv: 0, tag: tag};
    w = size_h_small ? PS : PB;
    h = size_v_small ? LS : LB;
    if (!disp_en) return e;                                  // R9
    if (x < hpos || x >= hpos + w || y < vpos || y >= vpos + h) return e; // R2 R3
    rx = x - hpos; ry = y - vpos;
    edge_px = (ry == 0) || (ry == h - 1) || (rx < BP) || (rx >= w - BP);  // R5
    if (bg_en) begin e.src = 3; e.fy = bg_y; e.fu = bg_u; e.fv = bg_v; end // R7
    else if (border_en && edge_px) begin
      e.src = 2;                                             // R6
      e.fy = border_indep ? border_y : 15;
      e.fu = border_indep ? border_u : 0;
      e.fv = border_indep ? border_v : 0;
    end else if (mute) begin e.src = 3; e.fy = bg_y; e.fu = bg_u; e.fv = bg_v; end // R8
    else begin e.src = 1; e.rv = 1; e.line = ry; e.pix = rx; end          // R4
    return e;
  endfunction

  // Driver: one frame of syncs, expected items pushed per pixel clock
  task automatic run_frame(input string tag);
    for (int ln = 0; ln < FRAME_LINES; ln++) begin
      for (int i = 0; i < LINE_LEN; i++) begin
        exp_t e;
        sw_t  s;
        @(negedge clk);
        hsync_i = (i == 0);
        vsync_i = (i == 0 && ln == 0);   // R11 line 0 starts with both edges
        e = model(i, ln, tag);
        e.due = cyc + 2;
        dq.push_back(e);
        s.due = cyc + 2 + int'(sw_dly); // R10
        s.sw = (e.src != 0) ? 1 : 0;
        s.tag = tag;
        sq.push_back(s);
      end
    end
    repeat (10) @(negedge clk);
  endtask

  // Monitor: compare outputs against due expectations
  always @(posedge clk) begin
    #1;
    if (dq.size() > 0 && dq[0].due == cyc) begin
      exp_t e;
      e = dq.pop_front();
      chk(int'(src_sel) == e.src, e.tag, "src_sel", int'(src_sel), e.src);
      chk(int'(rd_valid) == e.rv, e.tag, "rd_valid", int'(rd_valid), e.rv);
      chk(int'(rd_line) == e.line && int'(rd_pix) == e.pix, e.tag, "rd_addr",
          int'(rd_line) * 256 + int'(rd_pix), e.line * 256 + e.pix);
      chk(int'(fill_y) == e.fy && int'(fill_u) == e.fu && int'(fill_v) == e.fv, e.tag, "fill",
          int'({fill_y, fill_u, fill_v}), e.fy * 64 + e.fu * 8 + e.fv);
    end
    if (sq.size() > 0 && sq[0].due == cyc) begin
      sw_t s;
      s = sq.pop_front();
      chk(int'(fast_sw) == s.sw, s.tag, "fast_sw", int'(fast_sw), s.sw);
    end
  end

  task automatic set_ctrl(input bit de, input bit hs, input bit vs, input int hp, input int vp,
                          input bit be, input bit bi, input bit bg, input bit mu, input int d);
    @(negedge clk);
    disp_en = de; size_h_small = hs; size_v_small = vs;
    hpos = 8'(hp); vpos = 8'(vp); border_en = be; border_indep = bi;
    bg_en = bg; mute = mu; sw_dly = 2'(d);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: outputs idle in reset
    chk(src_sel == 0 && !rd_valid && !fast_sw && fill_y == 0, "R1", "reset outputs",
        int'({src_sel, rd_valid, fast_sw}), 0);
    rst_n = 1'b1;
    disp_en = 1'b1;
    repeat (6) @(negedge clk);
    // R1: nothing shown before the first frame edge
    chk(src_sel == 0 && !rd_valid && !fast_sw && fill_y == 0 && rd_pix == 0, "R1",
        "pre-frame outputs", int'({src_sel, rd_valid, fast_sw}), 0);
    bg_y = 4'd5; bg_u = 3'd2; bg_v = 3'd6;
    border_y = 4'd9; border_u = 3'd3; border_v = 3'd4;

    set_ctrl(1, 0, 0, 5, 2, 0, 0, 0, 0, 0);  run_frame("R2/R3/R4");      // large inset
    set_ctrl(1, 1, 1, 10, 3, 0, 0, 0, 0, 0); run_frame("R2/R3 small");   // small inset
    set_ctrl(1, 1, 1, 10, 3, 1, 0, 0, 0, 0); run_frame("R5/R6 default");
    set_ctrl(1, 1, 0, 0, 0, 1, 1, 0, 0, 0);  run_frame("R6/R11 corner"); // origin
    set_ctrl(1, 0, 0, 7, 4, 1, 1, 1, 0, 0);  run_frame("R7");
    set_ctrl(1, 0, 1, 7, 4, 1, 0, 0, 1, 0);  run_frame("R8");
    set_ctrl(0, 0, 0, 5, 2, 1, 1, 1, 1, 2);  run_frame("R9");
    set_ctrl(1, 0, 0, 5, 2, 1, 0, 0, 0, 1);  run_frame("R10 d1");
    set_ctrl(1, 1, 0, 5, 2, 0, 0, 0, 0, 2);  run_frame("R10 d2");
    set_ctrl(1, 0, 1, 5, 2, 1, 1, 0, 1, 3);  run_frame("R10 d3");

    chk(dq.size() == 0 && sq.size() == 0, "R10", "leftover expectations",
        dq.size() + sq.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule